// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block executes the memory-reference instructions of a 16-bit processor. When `start` is high while the block is idle, it decodes the instruction word and forms an effective address. The address is either the incremented program counter plus a sign-extended 9-bit offset, or a base register value plus a sign-extended 6-bit offset. The block then runs the memory accesses that the instruction needs on a simple synchronous memory port. Read data comes back one cycle after the address is presented.

Loads return a register writeback together with an N/Z/P condition update. The address-only load writes the address itself and never touches memory. The indirect forms make two accesses in sequence: the first read supplies the final address. Completion is marked by a single-cycle `done` pulse. The register file is read outside the block. The caller presents the register named by bits 8:6 on `base_val` and the register named by bits 11:9 on `src_val`, both in the cycle that `start` is high.

Top module: `ldst_seq`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr`, `done`, `wb_en` and `flag_we` are 0 and `nzp` is 3'b010 (Z set).
- R2: Opcode `instr[15:12]` selects the operation: 1110 address-only load, 0010 direct load, 1010 indirect load, 0110 base load, 0011 direct store, 1011 indirect store, 0111 base store. A start with any other opcode is ignored, and the block stays idle with no access and no `done`.
- R3: The address-only load produces `done`, `wb_en` and `flag_we` in the first cycle after the start edge. It writes `wb_data` = `pc_inc` + sign-extended `instr[8:0]` to register `instr[11:9]` and makes no memory access.
- R4: Direct and indirect loads and stores use `pc_inc` + sign-extended `instr[8:0]` as their first address.
- R5: Base loads and stores use `base_val` + sign-extended `instr[5:0]`.
- R6: A direct or base load asserts `mem_rd` with the address for the first cycle after the start edge. It completes two cycles later with `done` and `wb_en`, and `wb_data` equals the word read.
- R7: An indirect load reads the first address, then issues a second read two cycles later at the returned word, and completes two cycles after that with the second word as `wb_data`.
- R8: An indirect store reads the first address, then two cycles later asserts `mem_wr` at the returned word with `mem_wdata` = `src_val`, and asserts `done` in the following cycle.
- R9: A direct or base store asserts `mem_wr` for one cycle with `mem_wdata` = `src_val`, then asserts `done` without `wb_en`. Stores never change `nzp`.
- R10: On a load's completion, `nzp` becomes 3'b100 if bit 15 of the written value is set, 3'b010 if the value is zero, and 3'b001 otherwise. `nzp` is one-hot at all times and changes only when `flag_we` is high.
- R11: `mem_rd` and `mem_wr` are never high together, and `wb_en` is only high together with `done`.
- R12: A start presented while an instruction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled only when idle) |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Incremented program counter |
| base_val | input | 16 | Value of the register named by bits 8:6 |
| src_val | input | 16 | Value of the register named by bits 11:9 |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the read |
| wb_en | output | 1 | Register writeback strobe |
| wb_reg | output | 3 | Writeback register index |
| wb_data | output | 16 | Writeback value |
| flag_we | output | 1 | Condition code update strobe |
| nzp | output | 3 | Condition codes {N,Z,P} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the indirect forms. There the second address comes from memory contents, so the bench fills its memory with a computed pattern and keeps an identical reference copy. Its expected addresses then follow the pointer chain, including pointers written by earlier stores. A start held high with a different instruction through every busy cycle checks that the sequence in progress is not disturbed. Chosen offsets and values cover negative offsets and loaded words that are negative, zero and positive.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_ADR, K_LD, K_LDI, K_LDB, K_ST, K_STI, K_STB
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_GAP1, S_RD2, S_GAP2, S_WR
  } state_t;

  localparam logic [3:0] OPC_ADR = 4'b1110;
  localparam logic [3:0] OPC_LD  = 4'b0010;
  localparam logic [3:0] OPC_LDI = 4'b1010;
  localparam logic [3:0] OPC_LDB = 4'b0110;
  localparam logic [3:0] OPC_ST  = 4'b0011;
  localparam logic [3:0] OPC_STI = 4'b1011;
  localparam logic [3:0] OPC_STB = 4'b0111;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [3:0] opcode,
  output kind_t      kind,
  output logic       use_base
);
  always_comb begin
    case (opcode)
      OPC_ADR: kind = K_ADR;
      OPC_LD:  kind = K_LD;
      OPC_LDI: kind = K_LDI;
      OPC_LDB: kind = K_LDB;
      OPC_ST:  kind = K_ST;
      OPC_STI: kind = K_STI;
      OPC_STB: kind = K_STB;
      default: kind = K_NONE;
    endcase
    use_base = (kind == K_LDB) || (kind == K_STB);
  end
endmodule

// File: rtl/ldst_ea.sv
module ldst_ea #(
  parameter int W      = 16,
  parameter int OFF_PC = 9,
  parameter int OFF_BR = 6
) (
  input  logic [W-1:0]      pc_inc,
  input  logic [W-1:0]      base_val,
  input  logic [OFF_PC-1:0] off_pc,
  input  logic              use_base,
  output logic [W-1:0]      ea
);
  localparam int EXT_PC = W - OFF_PC;
  localparam int EXT_BR = W - OFF_BR;

  logic [W-1:0] sx_pc, sx_br;

  always_comb begin
    sx_pc = {{EXT_PC{off_pc[OFF_PC-1]}}, off_pc};
    sx_br = {{EXT_BR{off_pc[OFF_BR-1]}}, off_pc[OFF_BR-1:0]};
    ea    = use_base ? (base_val + sx_br) : (pc_inc + sx_pc);
  end
endmodule

// File: rtl/ldst_nzp.sv
module ldst_nzp #(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  output logic [2:0]   cc
);
  always_comb begin
    if (value[W-1])      cc = 3'b100;
    else if (value == '0) cc = 3'b010;
    else                 cc = 3'b001;
  end
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int W      = 16,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [W-1:0]      instr,
  input  logic [W-1:0]      pc_inc,
  input  logic [W-1:0]      base_val,
  input  logic [W-1:0]      src_val,
  output logic [W-1:0]      mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [W-1:0]      mem_wdata,
  input  logic [W-1:0]      mem_rdata,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_reg,
  output logic [W-1:0]      wb_data,
  output logic              flag_we,
  output logic [2:0]        nzp,
  output logic              done
);
  localparam int OFF_PC = 9;
  localparam int OP_LSB = W - 4;
  localparam int DR_LSB = OP_LSB - REG_AW;

  kind_t        dec_kind, cur_kind;
  state_t       state;
  logic         use_base;
  logic [W-1:0] ea, load_val, hold_src;
  logic [2:0]   load_cc;

  ldst_decode u_dec (
    .opcode   (instr[W-1:OP_LSB]),
    .kind     (dec_kind),
    .use_base (use_base)
  );

  ldst_ea #(.W(W), .OFF_PC(OFF_PC), .OFF_BR(6)) u_ea (
    .pc_inc   (pc_inc),
    .base_val (base_val),
    .off_pc   (instr[OFF_PC-1:0]),
    .use_base (use_base),
    .ea       (ea)
  );

  assign load_val = (state == S_IDLE) ? ea : mem_rdata;

  ldst_nzp #(.W(W)) u_cc (
    .value (load_val),
    .cc    (load_cc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_kind  <= K_NONE;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      hold_src  <= '0;
      wb_en     <= 1'b0;
      wb_reg    <= '0;
      wb_data   <= '0;
      flag_we   <= 1'b0;
      nzp       <= 3'b010;
      done      <= 1'b0;
    end else begin
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      wb_en   <= 1'b0;
      flag_we <= 1'b0;
      done    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && dec_kind != K_NONE) begin
            cur_kind <= dec_kind;
            wb_reg   <= instr[DR_LSB +: REG_AW];
            hold_src <= src_val;
            mem_addr <= ea;
            case (dec_kind)
              K_ADR: begin
                wb_en   <= 1'b1;
                wb_data <= load_val;
                flag_we <= 1'b1;
                nzp     <= load_cc;
                done    <= 1'b1;
              end
              K_ST, K_STB: begin
                mem_wr    <= 1'b1;
                mem_wdata <= src_val;
                state     <= S_WR;
              end
              default: begin
                mem_rd <= 1'b1;
                state  <= S_RD1;
              end
            endcase
          end
        end
        S_RD1: state <= S_GAP1;
        S_GAP1: begin
          if (cur_kind == K_LDI) begin
            mem_addr <= mem_rdata;
            mem_rd   <= 1'b1;
            state    <= S_RD2;
          end else if (cur_kind == K_STI) begin
            mem_addr  <= mem_rdata;
            mem_wr    <= 1'b1;
            mem_wdata <= hold_src;
            state     <= S_WR;
          end else begin
            wb_en   <= 1'b1;
            wb_data <= load_val;
            flag_we <= 1'b1;
            nzp     <= load_cc;
            done    <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_RD2: state <= S_GAP2;
        S_GAP2: begin
          wb_en   <= 1'b1;
          wb_data <= load_val;
          flag_we <= 1'b1;
          nzp     <= load_cc;
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        S_WR: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       wb_en,
  input logic       flag_we,
  input logic [2:0] nzp,
  input logic       done
);
  // R11
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R6
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (!mem_rd && !mem_wr && !done));

  // R9
  wr_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (done && !wb_en));

  // R10
  nzp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(nzp) == 1);

  // R10
  nzp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_we |-> $stable(nzp));

  // R11
  wb_done_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (done && flag_we));
endmodule

bind ldst_seq ldst_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .wb_en   (wb_en),
  .flag_we (flag_we),
  .nzp     (nzp),
  .done    (done)
);

// File: tb/ldst_seq_tb.sv
module ldst_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, src_val = '0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, wb_data;
  logic        mem_rd, mem_wr, wb_en, flag_we, done;
  logic [2:0]  wb_reg, nzp;

  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  logic [2:0]  exp_nzp;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_inc(pc_inc),
    .base_val(base_val), .src_val(src_val), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_data(wb_data), .flag_we(flag_we), .nzp(nzp), .done(done)
  );

  function automatic logic [15:0] init_word(int i);
    return 16'(i * 37 + 5) ^ ((i % 5 == 0) ? 16'h8000 : 16'h0000);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
      mem_rdata <= '0;
    end else begin
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  function automatic logic [2:0] cc_of(logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // One cycle of expected port values.
  task automatic check_cycle(string tag, bit e_rd, bit e_wr, logic [15:0] e_addr,
                             logic [15:0] e_wd, bit e_done, bit e_wb,
                             logic [2:0] e_reg, logic [15:0] e_wbd);
    bit bad;
    bad = (mem_rd !== e_rd) || (mem_wr !== e_wr) || (done !== e_done) ||
          (wb_en !== e_wb) || (flag_we !== e_wb) || (nzp !== exp_nzp);
    if ((e_rd || e_wr) && mem_addr !== e_addr) bad = 1;
    if (e_wr && mem_wdata !== e_wd) bad = 1;
    if (e_wb && (wb_reg !== e_reg || wb_data !== e_wbd)) bad = 1;
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got rd=%0b wr=%0b addr=%h wd=%h done=%0b wb=%0b reg=%0d wbd=%h nzp=%b; exp rd=%0b wr=%0b addr=%h wd=%h done=%0b wb=%0b reg=%0d wbd=%h nzp=%b",
               tag, mem_rd, mem_wr, mem_addr, mem_wdata, done, wb_en, wb_reg, wb_data, nzp,
               e_rd, e_wr, e_addr, e_wd, e_done, e_wb, e_reg, e_wbd, exp_nzp);
    end
  endtask

  // Drive one instruction and compare every cycle until done.
  task automatic run_op(string tag, logic [15:0] ins, logic [15:0] pc,
                        logic [15:0] bv, logic [15:0] sv, bit junk);
    logic [3:0]  op;
    logic [2:0]  dr;
    logic [15:0] ea, p, v;
    int n;
    bit rd[6], wr[6], dn[6], wb[6];
    logic [15:0] ad[6], wd[6], wv[6];
    op = ins[15:12];
    dr = ins[11:9];
    if (op == 4'b0110 || op == 4'b0111)
      ea = bv + {{10{ins[5]}}, ins[5:0]};
    else
      ea = pc + {{7{ins[8]}}, ins[8:0]};
    for (int k = 0; k < 6; k++) begin
      rd[k] = 0; wr[k] = 0; dn[k] = 0; wb[k] = 0; ad[k] = 0; wd[k] = 0; wv[k] = 0;
    end
    case (op)
      4'b1110: begin n = 1; dn[0] = 1; wb[0] = 1; wv[0] = ea; end
      4'b0010, 4'b0110: begin
        n = 3; rd[0] = 1; ad[0] = ea;
        dn[2] = 1; wb[2] = 1; wv[2] = ref_mem[ea[7:0]];
      end
      4'b1010: begin
        p = ref_mem[ea[7:0]];
        n = 5; rd[0] = 1; ad[0] = ea; rd[2] = 1; ad[2] = p;
        dn[4] = 1; wb[4] = 1; wv[4] = ref_mem[p[7:0]];
      end
      4'b0011, 4'b0111: begin
        n = 2; wr[0] = 1; ad[0] = ea; wd[0] = sv; dn[1] = 1;
        ref_mem[ea[7:0]] = sv;
      end
      4'b1011: begin
        p = ref_mem[ea[7:0]];
        n = 4; rd[0] = 1; ad[0] = ea; wr[2] = 1; ad[2] = p; wd[2] = sv; dn[3] = 1;
        ref_mem[p[7:0]] = sv;
      end
      default: n = 3;
    endcase
    @(negedge clk);
    start = 1; instr = ins; pc_inc = pc; base_val = bv; src_val = sv;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wb[k]) exp_nzp = cc_of(wv[k]);
      check_cycle(tag, rd[k], wr[k], ad[k], wd[k], dn[k], wb[k], dr, wv[k]);
      if (junk && k < n - 1) begin
        start = 1; instr = 16'hE1F0; pc_inc = 16'h0011;
        base_val = 16'h0022; src_val = 16'h0033;
      end else begin
        start = 0;
      end
    end
    v = 0;
    if (v != 0) start = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = init_word(i);
    exp_nzp = 3'b010;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check_cycle("R1 reset", 0, 0, 0, 0, 0, 0, 0, 0);

    // R3: address-only loads with positive, negative result and zero
    run_op("R3 adr pos", {4'b1110, 3'd2, 9'h005}, 16'h3050, 0, 0, 0);
    run_op("R3 adr neg R10", {4'b1110, 3'd4, 9'h001}, 16'hFFF0, 0, 0, 0);
    run_op("R3 adr zero R10", {4'b1110, 3'd1, 9'h1FF}, 16'h0001, 0, 0, 0);
    // R4 R6: direct load, negative offset
    run_op("R4 R6 ld", {4'b0010, 3'd3, 9'h1F0}, 16'h0120, 0, 0, 0);
    run_op("R6 ld other", {4'b0010, 3'd6, 9'h00A}, 16'h0040, 0, 0, 0);
    // R5: base load with negative offset
    run_op("R5 ldb", {4'b0110, 3'd5, 3'd2, 6'h3C}, 16'h9999, 16'h0080, 0, 0);
    // R9: stores leave flags unchanged
    run_op("R9 st", {4'b0011, 3'd1, 9'h010}, 16'h0030, 0, 16'h0000, 0);
    run_op("R4 R10 ld zero", {4'b0010, 3'd7, 9'h010}, 16'h0030, 0, 0, 0);
    run_op("R5 R9 stb", {4'b0111, 3'd2, 3'd1, 6'h05}, 0, 16'h0050, 16'h8123, 0);
    run_op("R5 ldb back", {4'b0110, 3'd0, 3'd1, 6'h05}, 0, 16'h0050, 0, 0);
    // R7: indirect load through a pointer
    run_op("R9 st ptr", {4'b0011, 3'd0, 9'h000}, 16'h0070, 0, 16'h0091, 0);
    run_op("R7 ldi", {4'b1010, 3'd2, 9'h000}, 16'h0070, 0, 0, 0);
    run_op("R7 ldi raw", {4'b1010, 3'd3, 9'h1FE}, 16'h00A2, 0, 0, 0);
    // R8: indirect store then reading the target back
    run_op("R8 sti", {4'b1011, 3'd4, 9'h000}, 16'h0070, 0, 16'h0777, 0);
    run_op("R8 ld target", {4'b0010, 3'd4, 9'h000}, 16'h0091, 0, 0, 0);
    // R2: undefined opcodes are ignored
    run_op("R2 bad op", {4'b0001, 12'h0AB}, 16'h0100, 0, 0, 0);
    run_op("R2 bad op2", {4'b1111, 12'h025}, 16'h0100, 0, 0, 0);
    // R12: start held during busy cycles is ignored
    run_op("R12 busy ldi", {4'b1010, 3'd1, 9'h000}, 16'h0070, 0, 0, 1);
    run_op("R12 busy sti", {4'b1011, 3'd5, 9'h000}, 16'h0070, 0, 16'h0042, 1);
    run_op("R12 busy st", {4'b0011, 3'd6, 9'h004}, 16'h0060, 0, 16'h1234, 1);
    run_op("R12 after", {4'b0010, 3'd6, 9'h004}, 16'h0060, 0, 0, 0);
    // R11: idle cycles with no activity
    repeat (2) begin
      @(negedge clk);
      check_cycle("R11 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      summary();
      $finish;
    end
  end
endmodule